// File: doc/BRIEF.md
# CPU Core Clock Gear with Halt and Sleep Gating

This block turns the free-running system clock into a core clock enable for the processor. A two-bit gear field selects the divide ratio, and the enable is a single-cycle pulse once every 1, 2, 4 or 8 system cycles. The block does not derive a new clock; the pulse qualifies the existing one. A peripheral clock enable is also produced, and it stays high whenever the system clock runs.

Two low-power states can be entered. In the halted state only the core enable stops: the system clock and the peripheral enable keep going, and any interrupt source resumes execution. In the sleeping state the whole system clock is stopped, modelled here by dropping the system-run output. Only an external interrupt brings the block back from sleep. The gear field is never altered by these transitions. After every wake, the divider restarts at its terminal count, so the core receives an enable in the first running cycle.

Top module: `core_clk_gear`

## Requirements
- R1: While running, the gear field value g (0, 1, 2, 3) gives a core_en pulse once every 2^g system cycles, that is ratios of 1, 2, 4 and 8.
- R2: In the first cycle after reset is released, core_en, sys_run and periph_en are all high, and pulses then repeat every cycle while the gear field is 0.
- R3: A new gear value is taken up only at the divider terminal count, when a pulse is issued. An interval already in progress completes at its old length and is never shortened.
- R4: A halt_req seen while running makes core_en low from the next cycle on, while sys_run and periph_en stay high.
- R5: While halted, nmi, irq or ext_irq returns the block to running in the next cycle, and core_en is high in that cycle.
- R6: A sleep_req seen while running drives sys_run, periph_en and core_en low from the next cycle on. sleep_req wins when it arrives together with halt_req.
- R7: While sleeping, nmi and irq have no effect. Only ext_irq wakes the block, and in the next cycle core_en, sys_run and periph_en are all high.
- R8: periph_en is high in every cycle in which the system clock runs, both while running and while halted.
- R9: After waking from halt or sleep, the unchanged gear field still sets the ratio. The first pulse comes in the first running cycle and the next one 2^g cycles later.
- R10: While running, the interrupt inputs do not disturb the pulse train. While halted, halt_req and sleep_req are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gear_sel | input | 2 | Divide selection, 2^gear_sel |
| halt_req | input | 1 | Request to enter the halted state |
| sleep_req | input | 1 | Request to enter the sleeping state |
| nmi | input | 1 | Non-maskable interrupt |
| irq | input | 1 | Enabled maskable interrupt |
| ext_irq | input | 1 | External interrupt |
| core_en | output | 1 | Core clock enable pulse |
| sys_run | output | 1 | System clock running |
| periph_en | output | 1 | Peripheral clock enable |

## Verification
The bench builds the block with its default gear width of 2, so the divider counter is 3 bits wide and the full set of ratios, 1 through 8, is exercised. The narrow counter keeps a pulse-counting window of 64 cycles exact for every gear. It also makes a gear change in the middle of the longest interval easy to observe, together with wakes from both low-power states using each interrupt source.

// File: rtl/core_clk_gear.sv
module core_clk_gear #(
  parameter int GEAR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GEAR_W-1:0] gear_sel,
  input  logic              halt_req,
  input  logic              sleep_req,
  input  logic              nmi,
  input  logic              irq,
  input  logic              ext_irq,
  output logic              core_en,
  output logic              sys_run,
  output logic              periph_en
);
  localparam int CNT_W = (1 << GEAR_W) - 1;

  typedef enum logic [1:0] {ST_RUN, ST_HALT, ST_SLEEP} gate_st_t;

  gate_st_t         state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   reload_w;

  wire running = (state_q == ST_RUN);
  wire at_tc   = (cnt_q == '0);

  assign reload_w = ({{CNT_W{1'b0}}, 1'b1} << gear_sel) - 1'b1;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:   if (sleep_req) state_d = ST_SLEEP;
                else if (halt_req) state_d = ST_HALT;
      ST_HALT:  if (nmi || irq || ext_irq) state_d = ST_RUN;
      ST_SLEEP: if (ext_irq) state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             cnt_q <= '0;
    else if (!running || state_d != ST_RUN) cnt_q <= '0;
    else if (at_tc)                         cnt_q <= reload_w[CNT_W-1:0];
    else                                    cnt_q <= cnt_q - 1'b1;
  end

  assign core_en   = running && at_tc;
  assign sys_run   = (state_q != ST_SLEEP);
  assign periph_en = sys_run;

  AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en && gear_sel == '0 && !halt_req && !sleep_req) |=> core_en); // R1
  AST_NO_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en && gear_sel != '0 && !halt_req && !sleep_req) |=> !core_en); // R3
  AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (running && halt_req && !sleep_req) |=> (!core_en && sys_run && periph_en)); // R4
  AST_HALT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT && (nmi || irq || ext_irq)) |=> core_en); // R5
  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (running && sleep_req) |=> (!sys_run && !periph_en && !core_en)); // R6
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && !ext_irq) |=> (!sys_run && !core_en)); // R7
  AST_SLEEP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && ext_irq) |=> (core_en && sys_run && periph_en)); // R7
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT && !nmi && !irq && !ext_irq) |=> (!core_en && sys_run)); // R10
endmodule

// File: tb/core_clk_gear_tb_top.sv
module core_clk_gear_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] gear_sel = 2'd0;
  logic halt_req = 0, sleep_req = 0, nmi = 0, irq = 0, ext_irq = 0;
  logic core_en, sys_run, periph_en;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  core_clk_gear dut_i (.clk, .rst_n, .gear_sel, .halt_req, .sleep_req,
                       .nmi, .irq, .ext_irq, .core_en, .sys_run, .periph_en);

  function automatic int ratio(input logic [1:0] g);
    return 1 << g;
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin tick(); n++; end while (!core_en && n < 40);
  endtask

  task automatic measure(input logic [1:0] g);
    int n, cnt;
    gear_sel = g;
    wait_pulse(n); wait_pulse(n);
    cnt = 0;
    for (int i = 0; i < 64; i++) begin tick(); if (core_en) cnt++; end
    chk(cnt, 64 / ratio(g), $sformatf("R1 gear=%0d pulses in 64", g));
  endtask

  task automatic do_halt(input int src, input logic [1:0] g);
    int n;
    gear_sel = g;
    halt_req = 1; tick(); halt_req = 0;
    chk(core_en, 0, "R4 core_en in halt");
    chk(sys_run, 1, "R4 sys_run in halt");
    chk(periph_en, 1, "R8 periph_en in halt");
    sleep_req = 1; halt_req = 1; tick(); sleep_req = 0; halt_req = 0;
    chk({core_en, sys_run}, 1, "R10 requests ignored in halt");
    case (src)
      0: nmi = 1;
      1: irq = 1;
      default: ext_irq = 1;
    endcase
    tick(); nmi = 0; irq = 0; ext_irq = 0;
    chk(core_en, 1, $sformatf("R5 wake src=%0d", src));
    wait_pulse(n);
    chk(n, ratio(g), "R9 ratio after halt");
  endtask

  task automatic do_sleep(input int noise, input logic [1:0] g, input bit both);
    int n;
    gear_sel = g;
    sleep_req = 1; halt_req = both; tick(); sleep_req = 0; halt_req = 0;
    chk({core_en, sys_run, periph_en}, 0, both ? "R6 sleep wins over halt" : "R6 sleep entry");
    for (int i = 0; i < noise; i++) begin
      nmi = i[0]; irq = ~i[0]; tick();
      chk({core_en, sys_run}, 0, "R7 nmi/irq ignored in sleep");
    end
    nmi = 0; irq = 0; ext_irq = 1; tick(); ext_irq = 0;
    chk({core_en, sys_run, periph_en}, 7, "R7 ext wake");
    wait_pulse(n);
    chk(n, ratio(g), "R9 ratio after sleep");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk); #2;
    chk({core_en, sys_run, periph_en}, 7, "R2 reset outputs before release");
    rst_n = 1; tick();
    chk({core_en, sys_run, periph_en}, 7, "R2 first cycle after reset");
    tick(); chk(core_en, 1, "R2 full rate after reset");
    chk(periph_en, 1, "R8 periph_en running");

    irq = 1; nmi = 1; ext_irq = 1;
    for (int i = 0; i < 4; i++) begin tick(); chk(core_en, 1, "R10 irqs ignored while running"); end
    irq = 0; nmi = 0; ext_irq = 0;

    for (int g = 0; g < 4; g++) measure(2'(g));

    gear_sel = 2'd3; wait_pulse(n); wait_pulse(n);
    chk(n, 8, "R3 settled interval 8");
    tick(); tick(); gear_sel = 2'd0;
    wait_pulse(n);
    chk(n, 6, "R3 old interval completes");
    tick(); chk(core_en, 1, "R3 new gear after terminal count");

    do_halt(0, 2'd2);
    do_halt(1, 2'd1);
    do_halt(2, 2'd3);
    do_sleep(5, 2'd2, 1'b0);
    do_sleep(2, 2'd1, 1'b1);

    for (int k = 0; k < 24; k++) begin
      int op = $urandom_range(0, 2);
      logic [1:0] g = 2'($urandom_range(0, 3));
      case (op)
        0: measure(g);
        1: do_halt($urandom_range(0, 2), g);
        default: do_sleep($urandom_range(0, 6), g, 1'($urandom_range(0, 1)));
      endcase
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule